// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Overrun Lock

This block receives asynchronous serial frames on one input line for a microcontroller-style serial port. A frame is a low start bit, then 8 data bits (or 9 when the nine-bit mode is on), least significant bit first, then a high stop bit. The line is oversampled from a programmable 8-bit divisor. Each bit is judged by a majority vote of three samples taken around its centre. A falling edge starts a frame, but the frame only goes ahead if the start bit still reads low at its centre.

Completed words, together with their 9th bit and their own framing-error flag, go into a two-entry receive buffer. Software drains the buffer with a read strobe. The interrupt output is high while any word is waiting. A word that completes while both entries are full sets a sticky overrun flag. While that flag is set, no words are stored. In address-detect mode only words whose 9th bit is 1 are kept.

Top module: `async_rx`

## Requirements
- R1: After reset, rx_irq, rx_oerr, rx_ferr, rx_bit8 and rx_data are all 0, the control register is 0 (receiver off) and the divisor is 0.
- R2: A cycle with wr_ctrl high loads wdata into the control register with this layout: bit0 port enable, bit1 continuous-receive enable, bit2 nine-bit mode, bit3 address detect, bit4 fast rate. A cycle with wr_div high loads the divisor. One bit lasts (divisor+1)*16 clocks, or (divisor+1)*4 clocks when the fast-rate bit is set.
- R3: Frames are received only while both the port-enable bit and the continuous-receive-enable bit are 1. With either bit at 0, frames on the line leave rx_irq at 0.
- R4: In 8-bit mode a frame's data bits, sent LSB first, appear on rx_data. rx_irq is 1 exactly while at least one word is buffered.
- R5: In nine-bit mode the 9th received bit appears on rx_bit8 with its word. In 8-bit mode rx_bit8 reads 0.
- R6: rx_ferr is 1 for a buffered word whose stop bit was sampled low. It always describes the word currently at the head of the buffer.
- R7: The buffer holds two words in arrival order. A cycle with rd_stb high removes the head word. rd_stb with an empty buffer has no effect. While the buffer is empty, rx_data, rx_bit8 and rx_ferr read 0.
- R8: A word that completes while two words are buffered, with no read in that cycle, is dropped and sets rx_oerr. While rx_oerr is 1, completed words are dropped.
- R9: rx_oerr stays 1 until the continuous-receive-enable bit is 0, which clears it.
- R10: With nine-bit mode and address detect both on, a word whose 9th bit is 0 is dropped without touching rx_irq. A word whose 9th bit is 1 is buffered.
- R11: A low pulse shorter than a third of a bit does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_i | input | 1 | Serial receive line, idle high |
| wr_ctrl | input | 1 | Write strobe for the control register |
| wr_div | input | 1 | Write strobe for the divisor register |
| wdata | input | 8 | Write data for either register |
| rd_stb | input | 1 | Removes the head word from the buffer |
| rx_data | output | 8 | Data byte of the head word |
| rx_bit8 | output | 1 | 9th bit of the head word |
| rx_ferr | output | 1 | Framing error of the head word |
| rx_oerr | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | High while the buffer holds a word |

## Verification
The assertions check, on every cycle, these rules:
- the overrun flag cannot clear while continuous receive is on, and always clears when it is off;
- the flag rises only when a word completes into a full buffer;
- the interrupt rises only after a completed frame;
- the head word holds steady until it is read;
- no frame completes while the receiver is disabled.

Only the bench's scenarios can show the rest:
- correct bit values, LSB-first order and the 9th bit;
- the two bit-rate formulas;
- arrival order through the buffer;
- glitch rejection;
- the address-detect filter.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int OS_SLOW = 16;
    localparam int OS_FAST = 4;
    localparam int PH_W    = $clog2(OS_SLOW);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit8;
        logic       ferr;
    } rx_word_t;

    typedef struct packed {
        logic fast;
        logic addr_det;
        logic nine;
        logic cont_en;
        logic port_en;
    } rx_ctrl_t;

    function automatic logic maj3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction

endpackage

// File: rtl/async_rx_baud.sv
module async_rx_baud #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = run && (cnt == div);
endmodule

// File: rtl/async_rx_frame.sv
module async_rx_frame
    import async_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     rx_s,
    input  logic     nine,
    input  logic     fast,
    input  logic     tick,
    output logic     run,
    output logic     done,
    output rx_word_t word
);
    rx_state_e       state;
    logic [PH_W-1:0] phase;
    logic [3:0]      bitcnt;
    logic [1:0]      samp;
    logic [8:0]      shreg;
    logic            rx_prev;

    logic [PH_W-1:0] os_last;
    logic [PH_W-1:0] mid;
    logic [3:0]      last_bit;
    logic            bit_now;

    always_comb begin
        os_last  = fast ? PH_W'(OS_FAST - 1) : PH_W'(OS_SLOW - 1);
        mid      = fast ? PH_W'(OS_FAST / 2) : PH_W'(OS_SLOW / 2);
        last_bit = nine ? 4'd8 : 4'd7;
        bit_now  = maj3(samp[1], samp[0], rx_s);
    end

    assign run = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            phase   <= '0;
            bitcnt  <= '0;
            samp    <= '1;
            shreg   <= '0;
            rx_prev <= 1'b1;
            done    <= 1'b0;
            word    <= '0;
        end else begin
            rx_prev <= rx_s;
            done    <= 1'b0;
            if (!en) begin
                state <= ST_IDLE;
            end else if (state == ST_IDLE) begin
                if (rx_prev && !rx_s) begin
                    state  <= ST_START;
                    phase  <= '0;
                    bitcnt <= '0;
                end
            end else if (tick) begin
                phase <= (phase == os_last) ? '0 : phase + 1'b1;
                samp  <= {samp[0], rx_s};
                case (state)
                    ST_START: begin
                        if (phase == mid && bit_now) begin
                            state <= ST_IDLE;
                        end else if (phase == os_last) begin
                            state <= ST_DATA;
                        end
                    end
                    ST_DATA: begin
                        if (phase == mid) begin
                            shreg <= {bit_now, shreg[8:1]};
                        end
                        if (phase == os_last) begin
                            if (bitcnt == last_bit) begin
                                state <= ST_STOP;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    ST_STOP: begin
                        if (phase == mid) begin
                            done      <= 1'b1;
                            word.ferr <= !bit_now;
                            if (nine) begin
                                word.data <= shreg[7:0];
                                word.bit8 <= shreg[8];
                            end else begin
                                word.data <= shreg[8:1];
                                word.bit8 <= 1'b0;
                            end
                            state <= ST_IDLE;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/async_rx_fifo.sv
module async_rx_fifo
    import async_rx_pkg::*;
#(
    parameter int DEPTH = 2,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  rx_word_t      din,
    input  logic          pop,
    output rx_word_t      dout,
    output logic [CW-1:0] count
);
    rx_word_t        mem [DEPTH];
    logic [AW-1:0]   rd_ptr;
    logic [AW-1:0]   wr_ptr;
    logic            pop_eff;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign pop_eff = pop && (count != '0);
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= din;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (pop_eff) begin
                rd_ptr <= nxt(rd_ptr);
            end
            case ({push, pop_eff})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/async_rx.sv
module async_rx
    import async_rx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int DEPTH       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_i,
    input  logic       wr_ctrl,
    input  logic       wr_div,
    input  logic [7:0] wdata,
    input  logic       rd_stb,
    output logic [7:0] rx_data,
    output logic       rx_bit8,
    output logic       rx_ferr,
    output logic       rx_oerr,
    output logic       rx_irq
);
    localparam int CW = $clog2(DEPTH + 1);

    rx_ctrl_t             ctrl_q;
    logic [DIV_W-1:0]     div_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                 rx_s;
    logic                 rx_en;
    logic                 cont_en;
    logic                 run;
    logic                 tick;
    logic                 frame_done;
    rx_word_t             frame_word;
    rx_word_t             head;
    logic [CW-1:0]        fifo_count;
    logic                 accept;
    logic                 full_now;
    logic                 push;
    logic                 oerr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            div_q  <= '0;
            sync_q <= '1;
        end else begin
            if (wr_ctrl) ctrl_q <= rx_ctrl_t'(wdata[$bits(rx_ctrl_t)-1:0]);
            if (wr_div)  div_q  <= wdata[DIV_W-1:0];
            sync_q <= {sync_q[SYNC_STAGES-2:0], rx_i};
        end
    end

    assign rx_s    = sync_q[SYNC_STAGES-1];
    assign cont_en = ctrl_q.cont_en;
    assign rx_en   = ctrl_q.port_en && ctrl_q.cont_en;

    async_rx_baud #(.DIV_W(DIV_W)) u_baud (
        .clk (clk),
        .rst (rst),
        .run (run),
        .div (div_q),
        .tick(tick)
    );

    async_rx_frame u_frame (
        .clk (clk),
        .rst (rst),
        .en  (rx_en),
        .rx_s(rx_s),
        .nine(ctrl_q.nine),
        .fast(ctrl_q.fast),
        .tick(tick),
        .run (run),
        .done(frame_done),
        .word(frame_word)
    );

    always_comb begin
        accept   = frame_done &&
                   !(ctrl_q.nine && ctrl_q.addr_det && !frame_word.bit8);
        full_now = (fifo_count == CW'(DEPTH)) && !(rd_stb && fifo_count != '0);
        push     = accept && !oerr_q && !full_now;
    end

    async_rx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk  (clk),
        .rst  (rst),
        .push (push),
        .din  (frame_word),
        .pop  (rd_stb),
        .dout (head),
        .count(fifo_count)
    );

    always_ff @(posedge clk) begin
        if (rst || !cont_en) begin
            oerr_q <= 1'b0;
        end else if (accept && !oerr_q && full_now) begin
            oerr_q <= 1'b1;
        end
    end

    assign rx_irq  = (fifo_count != '0);
    assign rx_data = rx_irq ? head.data : 8'h00;
    assign rx_bit8 = rx_irq && head.bit8;
    assign rx_ferr = rx_irq && head.ferr;
    assign rx_oerr = oerr_q;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
    parameter int DEPTH = 2,
    parameter int CW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          rx_irq,
    input logic          rx_oerr,
    input logic          rd_stb,
    input logic [7:0]    rx_data,
    input logic          rx_bit8,
    input logic          rx_ferr,
    input logic          cont_en,
    input logic          rx_en,
    input logic          frame_done,
    input logic [CW-1:0] fifo_count
);
    a_r9_oerr_sticky: assert property (@(posedge clk) disable iff (rst)
        rx_oerr && cont_en |=> rx_oerr);

    a_r9_oerr_clear: assert property (@(posedge clk) disable iff (rst)
        !cont_en |=> !rx_oerr);

    a_r8_oerr_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_oerr) |-> $past(frame_done) && ($past(fifo_count) == CW'(DEPTH)));

    a_r4_irq_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> $past(frame_done));

    a_r7_head_hold: assert property (@(posedge clk) disable iff (rst)
        rx_irq && !rd_stb |=> rx_irq && $stable({rx_data, rx_bit8, rx_ferr}));

    a_r3_quiet_off: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !frame_done);
endmodule

bind async_rx async_rx_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_irq    (rx_irq),
    .rx_oerr   (rx_oerr),
    .rd_stb    (rd_stb),
    .rx_data   (rx_data),
    .rx_bit8   (rx_bit8),
    .rx_ferr   (rx_ferr),
    .cont_en   (cont_en),
    .rx_en     (rx_en),
    .frame_done(frame_done),
    .fifo_count(fifo_count)
);

// File: tb/async_rx_tb.sv
`timescale 1ns/1ps
module async_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_i = 1'b1;
    logic       wr_ctrl = 1'b0;
    logic       wr_div = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit8;
    logic       rx_ferr;
    logic       rx_oerr;
    logic       rx_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    async_rx u_dut (
        .clk(clk), .rst(rst), .rx_i(rx_i), .wr_ctrl(wr_ctrl), .wr_div(wr_div),
        .wdata(wdata), .rd_stb(rd_stb), .rx_data(rx_data), .rx_bit8(rx_bit8),
        .rx_ferr(rx_ferr), .rx_oerr(rx_oerr), .rx_irq(rx_irq)
    );

    typedef struct packed {
        logic       nine;
        logic       fast;
        logic [7:0] div;
        logic [8:0] d9;
        logic       stop;
        logic [7:0] e_data;
        logic       e_b8;
        logic       e_ferr;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 8'd0, 9'h0A5, 1'b1, 8'hA5, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd3, 9'h13C, 1'b1, 8'h3C, 1'b0, 1'b0},
        '{1'b1, 1'b0, 8'd1, 9'h15A, 1'b1, 8'h5A, 1'b1, 1'b0},
        '{1'b1, 1'b1, 8'd3, 9'h0FF, 1'b1, 8'hFF, 1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd0, 9'h081, 1'b0, 8'h81, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd3, 9'h100, 1'b0, 8'h00, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk); wr_ctrl = 1'b1; wdata = v;
        @(negedge clk); wr_ctrl = 1'b0;
    endtask

    task automatic write_div(input logic [7:0] v);
        @(negedge clk); wr_div = 1'b1; wdata = v;
        @(negedge clk); wr_div = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic send(input logic [8:0] d, input logic nine, input logic stop, input int bl);
        @(negedge clk); rx_i = 1'b0;
        repeat (bl) @(negedge clk);
        for (int i = 0; i < (nine ? 9 : 8); i++) begin
            rx_i = d[i];
            repeat (bl) @(negedge clk);
        end
        rx_i = stop;
        repeat (bl) @(negedge clk);
        rx_i = 1'b1;
        repeat (2 * bl) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", rx_irq, 0);
        chk("R1 oerr", rx_oerr, 0);
        chk("R1 ferr", rx_ferr, 0);
        chk("R1 bit8", rx_bit8, 0);
        chk("R1 data", rx_data, 0);
        // R1/R3: receiver off after reset
        send(9'h0AA, 1'b0, 1'b1, 16);
        chk("R1 off after reset", rx_irq, 0);

        // R2 R4 R5 R6: table of frames
        for (int i = 0; i < NV; i++) begin
            write_div(VECS[i].div);
            write_ctrl({3'b000, VECS[i].fast, 1'b0, VECS[i].nine, 2'b11});
            send(VECS[i].d9, VECS[i].nine, VECS[i].stop,
                 (int'(VECS[i].div) + 1) * (VECS[i].fast ? 4 : 16));
            chk("R4 irq set", rx_irq, 1);
            chk("R2 R4 data", rx_data, VECS[i].e_data);
            chk("R5 bit8", rx_bit8, VECS[i].e_b8);
            chk("R6 ferr", rx_ferr, VECS[i].e_ferr);
            pop();
            chk("R7 irq after pop", rx_irq, 0);
        end

        // R3: one enable bit missing
        write_div(8'd0);
        write_ctrl(8'h02);
        send(9'h033, 1'b0, 1'b1, 16);
        chk("R3 port off", rx_irq, 0);
        write_ctrl(8'h01);
        send(9'h033, 1'b0, 1'b1, 16);
        chk("R3 cont off", rx_irq, 0);

        // R11: short glitch
        write_ctrl(8'h03);
        @(negedge clk); rx_i = 1'b0;
        repeat (3) @(negedge clk);
        rx_i = 1'b1;
        repeat (40) @(negedge clk);
        chk("R11 glitch", rx_irq, 0);

        // R7: pop on empty, then a normal frame
        pop();
        send(9'h0C3, 1'b0, 1'b1, 16);
        chk("R7 empty pop", rx_data, 8'hC3);
        pop();

        // R7 R8 R9: order and overrun
        send(9'h011, 1'b0, 1'b1, 16);
        send(9'h022, 1'b0, 1'b1, 16);
        chk("R8 no oerr at two", rx_oerr, 0);
        send(9'h033, 1'b0, 1'b1, 16);
        chk("R8 oerr set", rx_oerr, 1);
        chk("R7 head first", rx_data, 8'h11);
        pop();
        chk("R7 head second", rx_data, 8'h22);
        send(9'h044, 1'b0, 1'b1, 16);
        chk("R8 dropped while oerr", rx_data, 8'h22);
        pop();
        chk("R8 buffer drained", rx_irq, 0);
        chk("R9 oerr sticky", rx_oerr, 1);
        write_ctrl(8'h01);
        @(negedge clk);
        chk("R9 oerr cleared", rx_oerr, 0);
        write_ctrl(8'h03);
        send(9'h055, 1'b0, 1'b1, 16);
        chk("R8 recovered", rx_data, 8'h55);
        pop();

        // R10: address detect
        write_ctrl(8'h0F);
        send(9'h0A7, 1'b1, 1'b1, 16);
        chk("R10 bit8 zero dropped", rx_irq, 0);
        send(9'h1A7, 1'b1, 1'b1, 16);
        chk("R10 bit8 one kept", rx_irq, 1);
        chk("R10 data", rx_data, 8'hA7);
        chk("R10 bit8", rx_bit8, 1);
        pop();

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule